// File: doc/BRIEF.md
# Serial flash command sequencer

This block runs one serial flash command each time software writes its command register. A command is made of up to four phases, always in the same order. First an opcode byte, then 0 to 3 address bytes, then 0 to 15 dummy bytes, then a data phase of 0 to 4 bytes that is either written or read. A phase whose count is zero is skipped. The serial side is a half-duplex SPI link in mode 3 with one active-low select line per attached device. SCK is built from the system clock, and the timing register sets its period and the positions of its falling and rising edges.

A keep-selected flag holds the select line low once a command ends. Software can therefore build one long flash transaction out of several short commands. While the select line is held from an earlier command, the opcode phase is left out. A command that has no phases at all and has the flag clear only drops the select line. If software writes the command register while a command is still running, that write is refused and a sticky error flag is set.

Registers sit on a 32-bit word bus: 0 command, 1 address, 2 data, 3 status, 4 timing. Writes take effect at the clock edge. Reads are combinational.

Top module: `sflash_cmd_seq`

## Requirements
- R1: After reset every select line is high, SCK is high and the status word reads 0.
- R2: The command word holds the opcode in 7:0, the write flag in 8, the data count in 11:9, keep-selected in 15, the dummy count in 19:16, the address count in 22:20 and the select index in 26:24. A command sends the opcode, then the address, then the dummy bytes, then the data, and skips any phase whose count is zero.
- R3: The address phase sends the low N bytes of the address register, most significant byte first. Every byte on MOSI goes out MSB first.
- R4: In a write, the data bytes leave the data register starting with bits 7:0.
- R5: In a read, the first byte received lands in bits 7:0 of the data register and later bytes fill the bytes above it. The data register is cleared when a read command starts.
- R6: Status bit 22 is set from the accepting edge until the last bit ends. This lasts 8 × period clock cycles for each byte sent.
- R7: A command write while bit 22 is set is ignored, and it sets status bit 29. Bit 29 clears only when software writes 1 to it in the status register.
- R8: Writes to the address, data and timing registers while bit 22 is set are ignored.
- R9: With keep-selected set, the select line stays low after the command. The next command then skips its opcode phase.
- R10: A command with no phases to send and keep-selected clear only releases the select line, and it produces no SCK edge.
- R11: The timing register gives the period in 3:0, the rising position in 11:8 and the falling position in 15:12. SCK idles high and is low from the falling position to the rising position of each bit. MOSI changes only when SCK falls, and MISO is sampled when SCK rises.
- R12: MOSI is 0 for dummy bytes and for the bytes of a read data phase.
- R13: Only the select line picked by the command's index goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 3 | Register word index |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| sck_o | output | 1 | Serial clock, idles high |
| cs_no | output | NUM_CS | Active-low device selects |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
The checker assumes the timing register holds fall < rise < period with a period of at least 2. It also assumes the select index always names an existing select line, since a busy command must pull some line low. The bench writes only such timing values and indexes, and it drives MISO only after SCK falls. This keeps the sampled bit stable at each rising position.

// File: rtl/sflash_cmd_seq_pkg.sv
package sflash_cmd_seq_pkg;

  localparam int BYTE_W    = 8;
  localparam int DATA_MAX  = 4;
  localparam int ADDR_MAX  = 3;
  localparam int TIME_W    = 4;
  localparam int STAT_PEND = 22;
  localparam int STAT_ERR  = 29;

  localparam logic [2:0] REG_CMD  = 3'd0;
  localparam logic [2:0] REG_ADDR = 3'd1;
  localparam logic [2:0] REG_DATA = 3'd2;
  localparam logic [2:0] REG_STAT = 3'd3;
  localparam logic [2:0] REG_TIME = 3'd4;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_OPC   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4
  } phase_e;

  typedef struct packed {
    logic [7:0] opc;
    logic       wr;
    logic [2:0] dlen;
    logic       keep;
    logic [3:0] dum;
    logic [1:0] alen;
    logic [2:0] csi;
  } cmd_t;

  function automatic cmd_t decode_cmd(logic [31:0] w);
    cmd_t c;
    c.opc  = w[7:0];
    c.wr   = w[8];
    c.dlen = (w[11:9] > 3'd4) ? 3'd4 : w[11:9];
    c.keep = w[15];
    c.dum  = w[19:16];
    c.alen = w[22] ? 2'd3 : w[21:20];
    c.csi  = w[26:24];
    return c;
  endfunction

  // first phase after cur whose count is non-zero
  function automatic phase_e next_phase(phase_e cur, logic opc_en, cmd_t c);
    logic [4:1] en;
    phase_e r;
    en[1] = opc_en;
    en[2] = (c.alen != 2'd0);
    en[3] = (c.dum != 4'd0);
    en[4] = (c.dlen != 3'd0);
    r = PH_IDLE;
    for (int i = 4; i >= 1; i--)
      if (i > int'(cur) && en[i]) r = phase_e'(3'(i));
    return r;
  endfunction

  function automatic logic [3:0] phase_len(phase_e p, cmd_t c);
    case (p)
      PH_OPC:   return 4'd1;
      PH_ADDR:  return {2'b00, c.alen};
      PH_DUMMY: return c.dum;
      PH_DATA:  return {1'b0, c.dlen};
      default:  return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/sflash_sck_gen.sv
module sflash_sck_gen #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] rise_i,
  input  logic [CNT_W-1:0] fall_i,
  output logic             sck_o,
  output logic             fall_o,
  output logic             rise_o,
  output logic             bit_end_o
);

  logic [CNT_W-1:0] cnt_q;

  assign fall_o    = run_i && (cnt_q == fall_i);
  assign rise_o    = run_i && (cnt_q == rise_i);
  assign bit_end_o = run_i && (cnt_q == per_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_o <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_o <= 1'b1;
    end else begin
      cnt_q <= bit_end_o ? '0 : cnt_q + CNT_W'(1);
      if (fall_o)      sck_o <= 1'b0;
      else if (rise_o) sck_o <= 1'b1;
    end
  end

endmodule

// File: rtl/sflash_shift.sv
module sflash_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_byte_i,
  input  logic         fall_i,
  input  logic         rise_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic [W-1:0] rx_byte_o
);

  logic [W-1:0] tx_q, rx_q;

  // include the bit sampled this cycle when rise and byte end coincide
  assign rx_byte_o = rise_i ? {rx_q[W-2:0], miso_i} : rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      mosi_o <= 1'b0;
    end else begin
      if (load_i) begin
        tx_q <= load_byte_i;
      end else if (fall_i) begin
        mosi_o <= tx_q[W-1];
        tx_q   <= {tx_q[W-2:0], 1'b0};
      end
      if (rise_i) rx_q <= {rx_q[W-2:0], miso_i};
    end
  end

endmodule

// File: rtl/sflash_cmd_seq.sv
module sflash_cmd_seq
  import sflash_cmd_seq_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              sck_o,
  output logic [NUM_CS-1:0] cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);

  localparam int IDX_W = $clog2(DATA_MAX);
  localparam int REM_W = 4;

  logic [31:0]           cmd_w_q, addr_q, data_q;
  logic [4*TIME_W-1:0]   time_q;
  logic                  pend_q, err_q, held_q;
  cmd_t                  cmd_q, new_cmd, act_cmd;
  phase_e                ph_q, nxt_ph;
  logic [REM_W-1:0]      rem_q, nxt_rem;
  logic [IDX_W-1:0]      idx_q, nxt_idx;
  logic [2:0]            bit_q;
  logic                  load, fall, rise, bit_end, byte_done;
  logic [BYTE_W-1:0]     load_byte, rx_byte;
  logic                  wr_cmd, accept;

  assign wr_cmd    = reg_we_i && (reg_addr_i == REG_CMD);
  assign accept    = wr_cmd && !pend_q;
  assign new_cmd   = decode_cmd(reg_wdata_i);
  assign act_cmd   = accept ? new_cmd : cmd_q;
  assign byte_done = bit_end && (bit_q == 3'd7);

  sflash_sck_gen #(.CNT_W(TIME_W)) u_sck (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ph_q != PH_IDLE),
    .per_i    (time_q[TIME_W-1:0]),
    .rise_i   (time_q[3*TIME_W-1:2*TIME_W]),
    .fall_i   (time_q[4*TIME_W-1:3*TIME_W]),
    .sck_o    (sck_o),
    .fall_o   (fall),
    .rise_o   (rise),
    .bit_end_o(bit_end)
  );

  sflash_shift #(.W(BYTE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_byte_i(load_byte),
    .fall_i     (fall),
    .rise_i     (rise),
    .miso_i     (miso_i),
    .mosi_o     (mosi_o),
    .rx_byte_o  (rx_byte)
  );

  always_comb begin
    nxt_ph  = ph_q;
    nxt_rem = rem_q;
    nxt_idx = idx_q;
    load    = 1'b0;
    if (accept) begin
      nxt_ph  = next_phase(PH_IDLE, !held_q, new_cmd);
      nxt_rem = phase_len(nxt_ph, new_cmd);
      nxt_idx = '0;
      load    = (nxt_ph != PH_IDLE);
    end else if (byte_done) begin
      if (rem_q > REM_W'(1)) begin
        nxt_rem = rem_q - REM_W'(1);
        nxt_idx = idx_q + IDX_W'(1);
      end else begin
        nxt_ph  = next_phase(ph_q, 1'b0, cmd_q);
        nxt_rem = phase_len(nxt_ph, cmd_q);
        nxt_idx = '0;
      end
      load = (nxt_ph != PH_IDLE);
    end
  end

  always_comb begin
    case (nxt_ph)
      PH_OPC:  load_byte = act_cmd.opc;
      PH_ADDR: load_byte = addr_q[{nxt_rem[1:0] - 2'd1, 3'b000} +: BYTE_W];
      PH_DATA: load_byte = act_cmd.wr ? data_q[{nxt_idx, 3'b000} +: BYTE_W] : '0;
      default: load_byte = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_w_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      time_q  <= 16'h0204;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
      held_q  <= 1'b0;
      cmd_q   <= '0;
      ph_q    <= PH_IDLE;
      rem_q   <= '0;
      idx_q   <= '0;
      bit_q   <= '0;
    end else begin
      ph_q  <= nxt_ph;
      rem_q <= nxt_rem;
      idx_q <= nxt_idx;
      if (accept)       bit_q <= '0;
      else if (bit_end) bit_q <= bit_q + 3'd1;

      if (reg_we_i && !pend_q) begin
        case (reg_addr_i)
          REG_ADDR: addr_q <= reg_wdata_i;
          REG_DATA: data_q <= reg_wdata_i;
          REG_TIME: time_q <= reg_wdata_i[4*TIME_W-1:0];
          default: ;
        endcase
      end

      if (accept) begin
        cmd_q   <= new_cmd;
        cmd_w_q <= reg_wdata_i;
        if (nxt_ph != PH_IDLE) begin
          pend_q <= 1'b1;
          held_q <= 1'b1;
        end else begin
          held_q <= new_cmd.keep;
        end
        if (new_cmd.dlen != 3'd0 && !new_cmd.wr) data_q <= '0;
      end else if (byte_done) begin
        if (ph_q == PH_DATA && !cmd_q.wr)
          data_q[{idx_q, 3'b000} +: BYTE_W] <= rx_byte;
        if (nxt_ph == PH_IDLE) begin
          pend_q <= 1'b0;
          held_q <= cmd_q.keep;
        end
      end

      if (wr_cmd && pend_q)
        err_q <= 1'b1;
      else if (reg_we_i && reg_addr_i == REG_STAT && reg_wdata_i[STAT_ERR])
        err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_CMD:  reg_rdata_o = cmd_w_q;
      REG_ADDR: reg_rdata_o = addr_q;
      REG_DATA: reg_rdata_o = data_q;
      REG_STAT: begin
        reg_rdata_o[STAT_PEND] = pend_q;
        reg_rdata_o[STAT_ERR]  = err_q;
      end
      REG_TIME: reg_rdata_o = {{(32-4*TIME_W){1'b0}}, time_q};
      default:  reg_rdata_o = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_no[g] = !(held_q && (cmd_q.csi == 3'(g)));
  end

endmodule

// File: rtl/sflash_cmd_seq_chk.sv
module sflash_cmd_seq_chk
  import sflash_cmd_seq_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        reg_addr_i,
  input logic              reg_we_i,
  input logic              sck_o,
  input logic              mosi_o,
  input logic [NUM_CS-1:0] cs_no,
  input logic              pend_i,
  input logic              err_i
);

  p_cs_onehot_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  p_sck_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_i |-> sck_o);

  p_mosi_on_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_o) |-> !sck_o);

  p_busy_selects_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i |-> !(&cs_no));

  p_err_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_i) |-> $past(reg_we_i && reg_addr_i == REG_CMD && pend_i));

  p_busy_reject_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_CMD && pend_i) |=> err_i);

endmodule

bind sflash_cmd_seq sflash_cmd_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_addr_i(reg_addr_i),
  .reg_we_i  (reg_we_i),
  .sck_o     (sck_o),
  .mosi_o    (mosi_o),
  .cs_no     (cs_no),
  .pend_i    (pend_q),
  .err_i     (err_q)
);

// File: tb/sflash_cmd_seq_tb_top.sv
module sflash_cmd_seq_tb_top;

  localparam int NCS = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [2:0]      reg_addr_i = '0;
  logic            reg_we_i = 1'b0;
  logic [31:0]     reg_wdata_i = '0;
  logic [31:0]     reg_rdata_o;
  logic            sck_o, mosi_o;
  logic            miso_i = 1'b0;
  logic [NCS-1:0]  cs_no;

  int n_chk = 0;
  int n_err = 0;
  int done  = 0;

  sflash_cmd_seq #(.NUM_CS(NCS)) dut_i (.*);

  always #10 clk_i = ~clk_i;

  // flash model: log MOSI bytes, drive MISO pattern
  logic [7:0]  log_q [0:255];
  int          log_n = 0;
  int          nbits = 0;
  logic [7:0]  cur = '0;
  logic [63:0] pat = '0;
  int          sck_rises = 0;
  wire         any_sel = !(&cs_no);

  always @(posedge sck_o) begin
    sck_rises = sck_rises + 1;
    if (any_sel) begin
      cur = {cur[6:0], mosi_o};
      nbits = nbits + 1;
      if (nbits == 8) begin
        log_q[log_n[7:0]] = cur;
        log_n = log_n + 1;
        nbits = 0;
      end
    end
  end

  always @(negedge sck_o) if (any_sel) begin
    miso_i <= pat[63];
    pat = {pat[62:0], 1'b0};
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 5000; k++) begin
      reg_rd(3'd3, s);
      if (!s[22]) return;
    end
    n_chk++; n_err++;
    $display("FAIL R6: pending never cleared, actual 1 expected 0");
  endtask

  function automatic logic [31:0] mk(input logic [7:0] opc, input logic wr,
      input logic [2:0] dl, input logic kp, input logic [3:0] dm,
      input logic [2:0] al, input logic [2:0] cs);
    return {5'd0, cs, 1'b0, al, dm, kp, 3'd0, dl, wr, opc};
  endfunction

  task automatic t_reset();
    logic [31:0] s;
    chk("R1 cs", 32'(cs_no), 32'hFF);
    chk("R1 sck", 32'(sck_o), 32'd1);
    reg_rd(3'd3, s);
    chk("R1 status", s, 32'd0);
  endtask

  task automatic t_opcode_only();
    int st = log_n;
    reg_wr(3'd0, mk(8'h06, 0, 0, 0, 0, 0, 1));
    chk("R13 select 1", 32'(cs_no), 32'hFD);
    wait_idle();
    chk("R2 opcode-only count", 32'(log_n - st), 32'd1);
    chk("R2 opcode byte", 32'(log_q[st[7:0]]), 32'h06);
    chk("R9 released", 32'(cs_no), 32'hFF);
  endtask

  task automatic t_write();
    int st;
    logic [7:0] e [0:7];
    e = '{8'h02, 8'h34, 8'h56, 8'h78, 8'hAA, 8'hBB, 8'hCC, 8'hDD};
    reg_wr(3'd1, 32'h12345678);
    reg_wr(3'd2, 32'hDDCCBBAA);
    st = log_n;
    reg_wr(3'd0, mk(8'h02, 1, 4, 0, 0, 3, 2));
    chk("R13 select 2", 32'(cs_no), 32'hFB);
    wait_idle();
    chk("R2 write count", 32'(log_n - st), 32'd8);
    for (int i = 0; i < 8; i++)
      chk(i < 4 ? "R3 addr/opc byte" : "R4 write byte", 32'(log_q[8'(st + i)]), 32'(e[i]));
  endtask

  task automatic t_read_dummy();
    int st = log_n;
    logic [31:0] d;
    pat = {40'h0, 24'hA1B2C3};
    reg_wr(3'd0, mk(8'h0B, 0, 3, 0, 1, 3, 0));
    wait_idle();
    chk("R2 read count", 32'(log_n - st), 32'd8);
    chk("R2 opcode first", 32'(log_q[st[7:0]]), 32'h0B);
    for (int i = 4; i < 8; i++)
      chk("R12 mosi zero", 32'(log_q[8'(st + i)]), 32'h0);
    reg_rd(3'd2, d);
    chk("R5 read data", d, 32'h00C3B2A1);
  endtask

  task automatic t_chain();
    int st, rises;
    logic [31:0] d;
    reg_wr(3'd1, 32'h0000ABCD);
    st = log_n;
    reg_wr(3'd0, mk(8'h03, 0, 0, 1, 0, 2, 3));
    wait_idle();
    chk("R3 two-byte addr count", 32'(log_n - st), 32'd3);
    chk("R3 addr msb", 32'(log_q[8'(st + 1)]), 32'hAB);
    chk("R3 addr lsb", 32'(log_q[8'(st + 2)]), 32'hCD);
    chk("R9 held", 32'(cs_no), 32'hF7);
    pat = {16'h5AC3, 48'h0};
    reg_wr(3'd0, mk(8'h03, 0, 2, 1, 0, 0, 3));
    wait_idle();
    chk("R9 no opcode resend", 32'(log_n - st), 32'd5);
    reg_rd(3'd2, d);
    chk("R5 chained read", d, 32'h0000C35A);
    chk("R9 still held", 32'(cs_no), 32'hF7);
    rises = sck_rises;
    reg_wr(3'd0, mk(8'h03, 0, 0, 0, 0, 0, 3));
    chk("R10 release", 32'(cs_no), 32'hFF);
    reg_rd(3'd3, d);
    chk("R10 not pending", d, 32'd0);
    chk("R10 no sck", 32'(sck_rises - rises), 32'd0);
  endtask

  task automatic t_error();
    int st = log_n;
    logic [31:0] d;
    reg_wr(3'd0, mk(8'h05, 0, 1, 0, 0, 0, 0));
    repeat (4) @(negedge clk_i);
    reg_wr(3'd0, mk(8'hAB, 1, 0, 1, 0, 0, 4));
    reg_rd(3'd3, d);
    chk("R7 error set", d, 32'h2040_0000);
    reg_wr(3'd1, 32'hFFFFFFFF);
    reg_wr(3'd4, 32'h0000_1306);
    wait_idle();
    chk("R7 ignored cmd count", 32'(log_n - st), 32'd2);
    chk("R7 first opcode", 32'(log_q[st[7:0]]), 32'h05);
    chk("R7 keep not applied", 32'(cs_no), 32'hFF);
    reg_rd(3'd1, d);
    chk("R8 addr kept", d, 32'h0000ABCD);
    reg_rd(3'd4, d);
    chk("R8 timing kept", d, 32'h0000_0204);
    reg_rd(3'd3, d);
    chk("R7 sticky", d, 32'h2000_0000);
    reg_wr(3'd3, 32'h2000_0000);
    reg_rd(3'd3, d);
    chk("R7 cleared", d, 32'd0);
  endtask

  task automatic t_timing();
    int pc = 0, lc = 0;
    reg_wr(3'd4, 32'h0000_1306);
    reg_wr(3'd0, mk(8'h9F, 0, 0, 0, 0, 0, 5));
    reg_addr_i = 3'd3;
    #1;
    for (int k = 0; k < 1000; k++) begin
      if (!reg_rdata_o[22]) break;
      pc++;
      if (!sck_o) lc++;
      @(negedge clk_i);
      #1;
    end
    chk("R6 pending cycles", 32'(pc), 32'd48);
    chk("R11 sck low cycles", 32'(lc), 32'd16);
    reg_wr(3'd4, 32'h0000_0204);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_opcode_only();
    t_write();
    t_read_dummy();
    t_chain();
    t_error();
    t_timing();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (done == 0) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule